// File: doc/BRIEF.md
# Audio transmit FIFO with packing

This block is the transmit sample queue of an audio serial-link controller. A host writes 32-bit words through a small register port. Each word becomes one or two 20-bit samples, left-aligned according to the selected sample width, and goes into a FIFO whose depth is a parameter. A stereo pair (left and right) is handed to the codec side over a valid/ready handshake, one pair per accepted cycle.

Data does not move as each sample arrives. The block waits until the queue is at least half full and then runs a burst that continues until fewer than two samples remain. Status flags track the queue's empty, half-empty, full and underrun conditions. Three interrupt sources are derived from those flags and combined through an enable mask into a single interrupt line. A write to the main control register that clears its enable bit acts as a full soft reset.

Top module: `aud_tx_pack`

## Requirements
- R1: The control register (address 0) holds these fields: bit 0 transmit enable, bit 1 slot-3 enable, bit 2 slot-4 enable, bits [4:3] sample size, and bit 5 compact request. The size code is 0 for 16-bit, 1 for 18-bit, 2 for 20-bit and 3 for 12-bit samples. The compact request is ignored when the size is 18 or 20 bits.
- R2: In non-compact mode, a write to the data address (2) stores one sample. The sample is the word shifted left by 8 (12-bit), 4 (16-bit), 2 (18-bit) or 0 (20-bit) and then truncated to 20 bits.
- R3: In compact mode, a data write stores two samples. Bits [15:0] are stored first and bits [31:16] second. Each half is shifted left by 8 for 12-bit size or by 4 for 16-bit size, then truncated to 20 bits.
- R4: A non-compact write is accepted only while the level is below the depth. Otherwise it is dropped and the queue is unchanged.
- R5: A compact write is accepted only while the level plus two is strictly below the depth. Otherwise both samples are dropped.
- R6: The status register (address 5) reads bit 0 empty, bit 1 half-empty, bit 2 full, bit 3 underrun and bit 4 busy (a pair is being offered). After any data write, a nonzero level clears empty and underrun. A level of at least half the depth clears half-empty. A level at or above the depth sets full.
- R7: A pair is offered only when all of these hold: transmit is enabled, slot 3 or slot 4 is enabled, and the level is at least two. In addition, either the level is at least half the depth or a burst is already running.
- R8: Pairs leave from the head of the queue, with the older sample on the left output. Each cycle with valid and ready high removes one pair. A burst keeps the offer up, even across cycles where ready is low, until fewer than two samples remain.
- R9: When a pair leaves, full clears. If the new level is at most half the depth, half-empty sets. If the new level is zero, empty and underrun both set.
- R10: The interrupt register (address 6) reads bit 0 underrun, bit 1 half-empty and bit 2 transfer-complete (empty and not busy). Higher bits read zero. The interrupt output is high when any of these bits is high together with the matching bit of the mask register (address 4).
- R11: Writing a 1 in bit 0 of the clear register (address 3) clears the underrun flag.
- R12: After the reset input, the status reads empty and half-empty only, and the queue, control and mask are cleared. A write to the main control register (address 1) with bit 0 low has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| tx_valid | output | 1 | Stereo pair offered |
| tx_ready | input | 1 | Codec side accepts the pair |
| tx_left | output | 20 | Older sample of the pair |
| tx_right | output | 20 | Newer sample of the pair |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is a burst that is already running when new data arrives. The burst has dropped below the half mark, ready is high, a host write lands in the same cycle as a pop, and an odd sample is left behind. The stimulus gets there by keeping ready high while writing one sample at a time: the queue crosses half full, starts draining, and the next write meets the second pop. A second hard case is the overrun boundaries, the last free slot and the compact case that can never fill the queue. The stimulus holds ready low so the level can be counted exactly, then writes past the limit. A scoreboard of expected samples, built from the shift rules, confirms that nothing dropped ever appears on the output.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic [1:0] {
      SZ16 = 2'd0,
      SZ18 = 2'd1,
      SZ20 = 2'd2,
      SZ12 = 2'd3
   } smp_size_e;

   // control fields, LSB first: enable, slot3, slot4, size, compact
   typedef struct packed {
      logic      compact;
      smp_size_e size;
      logic      slot4;
      logic      slot3;
      logic      tx_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_MAIN  = 3'd1;
   localparam logic [2:0] A_DATA  = 3'd2;
   localparam logic [2:0] A_ICLR  = 3'd3;
   localparam logic [2:0] A_IMASK = 3'd4;
   localparam logic [2:0] A_STAT  = 3'd5;
   localparam logic [2:0] A_INTS  = 3'd6;

   localparam int INT_UR = 0;
   localparam int INT_TX = 1;
   localparam int INT_TC = 2;
   localparam int NINT   = 3;

   function automatic logic [3:0] nc_shift(smp_size_e s);
      case (s)
         SZ12:    return 4'd8;
         SZ16:    return 4'd4;
         SZ18:    return 4'd2;
         default: return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/aud_tx_ctrl_dec.sv
module aud_tx_ctrl_dec
   import aud_tx_pkg::*;
(
   input  ctrl_t     ctrl_q,
   output logic      drain_allow,
   output smp_size_e size,
   output logic      compact_eff
);

   always_comb begin
      size        = ctrl_q.size;
      drain_allow = ctrl_q.tx_en & (ctrl_q.slot3 | ctrl_q.slot4);
      compact_eff = ctrl_q.compact & ((ctrl_q.size == SZ16) | (ctrl_q.size == SZ12));
   end

endmodule

// File: rtl/aud_tx_packer.sv
module aud_tx_packer
   import aud_tx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SAMPLE_W = 20,
   parameter int LANE_W   = 16
) (
   input  logic [DATA_W-1:0]              word,
   input  smp_size_e                      size,
   input  logic                           compact,
   output logic [1:0][SAMPLE_W-1:0]       smp,
   output logic [1:0]                     cnt
);

   localparam int NLANE = 2;

   if (DATA_W < NLANE * LANE_W || SAMPLE_W <= LANE_W) begin : g_bad_widths
      $error("aud_tx_packer: word must hold two lanes and a sample must exceed a lane");
   end

   logic [NLANE-1:0][SAMPLE_W-1:0] lane_smp;
   logic [3:0]                     lane_sh;
   logic [SAMPLE_W-1:0]            nc_smp;

   always_comb lane_sh = (size == SZ12) ? 4'd8 : 4'd4;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      logic [LANE_W-1:0] lane;
      always_comb begin
         lane        = word[i*LANE_W +: LANE_W];
         lane_smp[i] = SAMPLE_W'(lane) << lane_sh;
      end
   end

   if (DATA_W > NLANE * LANE_W) begin : g_spare
      logic spare_or;
      always_comb spare_or = |word[DATA_W-1:NLANE*LANE_W];
   end

   always_comb begin
      nc_smp = word[SAMPLE_W-1:0] << nc_shift(size);
      if (compact) begin
         smp = lane_smp;
         cnt = 2'd2;
      end else begin
         smp[0] = nc_smp;
         smp[1] = '0;
         cnt    = 2'd1;
      end
   end

endmodule

// File: rtl/aud_tx_store.sv
module aud_tx_store #(
   parameter int SAMPLE_W = 20,
   parameter int DEPTH    = 8,
   localparam int PW      = $clog2(DEPTH),
   localparam int LW      = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic [1:0]                push_n,
   input  logic [1:0][SAMPLE_W-1:0]  push_smp,
   input  logic                      pop,
   output logic [LW-1:0]             level,
   output logic [SAMPLE_W-1:0]       head_l,
   output logic [SAMPLE_W-1:0]       head_r
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("aud_tx_store: DEPTH must be a power of two of at least 4");
   end

   logic [SAMPLE_W-1:0] mem [DEPTH];
   logic [PW-1:0]       wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (push_n != 2'd0) mem[wr_ptr] <= push_smp[0];
         if (push_n == 2'd2) mem[wr_ptr + PW'(1)] <= push_smp[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PW'(push_n);
         if (pop) rd_ptr <= rd_ptr + PW'(2);
         level <= level + LW'(push_n) - (pop ? LW'(2) : LW'(0));
      end
   end

   always_comb begin
      head_l = mem[rd_ptr];
      head_r = mem[rd_ptr + PW'(1)];
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> level >= LW'(2)); // R8
   AST_POP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |=> level == $past(level) + LW'($past(push_n)) - LW'(2)); // R8

endmodule

// File: rtl/aud_tx_pack.sv
module aud_tx_pack
   import aud_tx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SAMPLE_W = 20,
   parameter int LANE_W   = 16,
   parameter int DEPTH    = 8,
   parameter int AW       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [AW-1:0]       reg_waddr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [AW-1:0]       reg_raddr,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                tx_valid,
   input  logic                tx_ready,
   output logic [SAMPLE_W-1:0] tx_left,
   output logic [SAMPLE_W-1:0] tx_right,
   output logic                irq
);

   localparam int LW   = $clog2(DEPTH + 1);
   localparam int HALF = DEPTH / 2;

   if (AW != 3 || DATA_W < CTRL_W) begin : g_bad_port
      $error("aud_tx_pack: register map needs 3 address bits and room for control");
   end

   ctrl_t           ctrl_q;
   logic            main_q;
   logic [NINT-1:0] mask_q;
   logic            empty_q, half_q, full_q, under_q, burst_q;

   logic            drain_allow, compact_eff;
   smp_size_e       size;
   logic [1:0][SAMPLE_W-1:0] pk_smp;
   logic [1:0]      pk_cnt;
   logic [LW-1:0]   level, level_nx;
   logic [1:0]      push_n;
   logic            accept, pop, busy;
   logic            soft_rst, data_wr, iclr_hit;
   logic [NINT-1:0] ints;

   // register write decode
   always_comb begin
      soft_rst = reg_wr && (reg_waddr == A_MAIN) && !reg_wdata[0];
      data_wr  = reg_wr && (reg_waddr == A_DATA);
      iclr_hit = reg_wr && (reg_waddr == A_ICLR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         main_q <= 1'b0;
         mask_q <= '0;
      end else if (soft_rst) begin
         ctrl_q <= '0;
         main_q <= 1'b0;
         mask_q <= '0;
      end else if (reg_wr) begin
         case (reg_waddr)
            A_CTRL:  ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            A_MAIN:  main_q <= reg_wdata[0];
            A_IMASK: mask_q <= reg_wdata[NINT-1:0];
            default: ;
         endcase
      end
   end

   aud_tx_ctrl_dec u_dec (
      .ctrl_q      (ctrl_q),
      .drain_allow (drain_allow),
      .size        (size),
      .compact_eff (compact_eff)
   );

   aud_tx_packer #(
      .DATA_W   (DATA_W),
      .SAMPLE_W (SAMPLE_W),
      .LANE_W   (LANE_W)
   ) u_pack (
      .word    (reg_wdata),
      .size    (size),
      .compact (compact_eff),
      .smp     (pk_smp),
      .cnt     (pk_cnt)
   );

   // overrun screening and drain control
   always_comb begin
      accept   = compact_eff ? ((level + LW'(2)) < LW'(DEPTH)) : (level < LW'(DEPTH));
      push_n   = (data_wr && accept) ? pk_cnt : 2'd0;
      tx_valid = drain_allow && (level >= LW'(2)) && (burst_q || level >= LW'(HALF));
      pop      = tx_valid && tx_ready;
      busy     = tx_valid;
      level_nx = level + LW'(push_n) - (pop ? LW'(2) : LW'(0));
   end

   aud_tx_store #(
      .SAMPLE_W (SAMPLE_W),
      .DEPTH    (DEPTH)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (soft_rst),
      .push_n   (push_n),
      .push_smp (pk_smp),
      .pop      (pop),
      .level    (level),
      .head_l   (tx_left),
      .head_r   (tx_right)
   );

   // status flags: clear request, then drain effects, then write effects
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         half_q  <= 1'b1;
         full_q  <= 1'b0;
         under_q <= 1'b0;
         burst_q <= 1'b0;
      end else if (soft_rst) begin
         empty_q <= 1'b1;
         half_q  <= 1'b1;
         full_q  <= 1'b0;
         under_q <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         burst_q <= tx_valid && (level_nx >= LW'(2));
         if (iclr_hit && reg_wdata[0]) under_q <= 1'b0;
         if (pop) begin
            full_q <= 1'b0;
            if (level_nx <= LW'(HALF)) half_q <= 1'b1;
            if (level_nx == '0) begin
               empty_q <= 1'b1;
               under_q <= 1'b1;
            end
         end
         if (data_wr) begin
            if (level_nx != '0) begin
               empty_q <= 1'b0;
               under_q <= 1'b0;
            end
            if (level_nx >= LW'(HALF))  half_q <= 1'b0;
            if (level_nx >= LW'(DEPTH)) full_q <= 1'b1;
         end
      end
   end

   // interrupts
   always_comb begin
      ints         = '0;
      ints[INT_UR] = under_q;
      ints[INT_TX] = half_q;
      ints[INT_TC] = empty_q & ~busy;
      irq          = |(ints & mask_q);
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
         A_MAIN:  reg_rdata[0] = main_q;
         A_IMASK: reg_rdata[NINT-1:0] = mask_q;
         A_STAT:  reg_rdata[4:0] = {busy, under_q, full_q, half_q, empty_q};
         A_INTS:  reg_rdata[NINT-1:0] = ints;
         default: reg_rdata = '0;
      endcase
   end

   AST_COMPACT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      compact_eff |-> (ctrl_q.size == SZ16 || ctrl_q.size == SZ12)); // R1
   AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !compact_eff && level == LW'(DEPTH) && !pop) |=> level == LW'(DEPTH)); // R4
   AST_EMPTY_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      empty_q |-> level == '0); // R6
   AST_FULL_MEANS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> level == LW'(DEPTH)); // R6
   AST_VALID_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !empty_q); // R7
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mask_q != '0); // R10
   AST_UNDER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (iclr_hit && reg_wdata[0] && !pop) |=> !under_q); // R11
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (empty_q && !tx_valid && ctrl_q == '0)); // R12

endmodule

// File: tb/aud_tx_pack_tb.sv
module aud_tx_pack_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [19:0] tx_left, tx_right;
   logic        irq;

   int          n_chk = 0;
   int          n_bad = 0;
   int          exp_lvl = 0;
   logic [19:0] exp_q [$];
   logic [19:0] e0, e1;
   logic [1:0]  b_size = 2'd0;
   bit          b_cmp = 1'b0;
   string       cur_req = "R8";
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aud_tx_pack #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left),
      .tx_right(tx_right), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] stat(bit e, bit h, bit f, bit u, bit b);
      return {27'd0, b, u, f, h, e};
   endfunction

   function automatic logic [19:0] nc_exp(logic [31:0] v);
      logic [31:0] t;
      case (b_size)
         2'd3:    t = v << 8;
         2'd0:    t = v << 4;
         2'd1:    t = v << 2;
         default: t = v;
      endcase
      return t[19:0];
   endfunction

   function automatic logic [19:0] lane_exp(logic [15:0] l);
      logic [31:0] t;
      t = {16'd0, l} << ((b_size == 2'd3) ? 8 : 4);
      return t[19:0];
   endfunction

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_ctrl(input bit en, input bit s3, input bit s4, input logic [1:0] sz, input bit cmp);
      b_size = sz;
      b_cmp  = cmp;
      wr_reg(3'd0, {26'd0, cmp, sz, s4, s3, en});
   endtask

   // driver: predicts acceptance and pushes expected samples
   task automatic push_word(input logic [31:0] v);
      bit ce, ok;
      @(negedge clk);
      ce = b_cmp && (b_size == 2'd0 || b_size == 2'd3);
      ok = ce ? (exp_lvl + 2 < DEPTH) : (exp_lvl < DEPTH);
      if (ok) begin
         if (ce) begin
            exp_q.push_back(lane_exp(v[15:0]));
            exp_q.push_back(lane_exp(v[31:16]));
            exp_lvl += 2;
         end else begin
            exp_q.push_back(nc_exp(v));
            exp_lvl += 1;
         end
      end
      reg_wr = 1'b1; reg_waddr = 3'd2; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic drain(input int n);
      @(negedge clk);
      tx_ready = 1'b1;
      repeat (n) @(negedge clk);
      tx_ready = 1'b0;
      #1;
   endtask

   task automatic soft_reset();
      wr_reg(3'd1, 32'd0);
      exp_q.delete();
      exp_lvl = 0;
      b_size = 2'd0;
      b_cmp = 1'b0;
   endtask

   // monitor: compares each accepted pair against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() < 2) begin
               n_chk++;
               n_bad++;
               $display("FAIL %s actual=unexpected pair %h/%h expected=none", cur_req, tx_left, tx_right);
            end else begin
               e0 = exp_q.pop_front();
               e1 = exp_q.pop_front();
               chk({cur_req, " left"}, {12'd0, tx_left}, {12'd0, e0});
               chk({cur_req, " right"}, {12'd0, tx_right}, {12'd0, e1});
            end
            exp_lvl -= 2;
         end
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12 reset state
      rd_reg(3'd5, d); chk("R12 status after reset", d, stat(1, 1, 0, 0, 0));
      rd_reg(3'd6, d); chk("R10 ints after reset", d, 32'h6);
      chk("R12 irq after reset", {31'd0, irq}, 32'd0);
      chk("R12 valid after reset", {31'd0, tx_valid}, 32'd0);
      wr_reg(3'd1, 32'd1);

      // 16-bit non-compact, half-full start
      cur_req = "R2";
      set_ctrl(1, 1, 0, 2'd0, 0);
      push_word(32'h0000_1234);
      push_word(32'hFFFF_5678);
      push_word(32'h0000_ABCD);
      rd_reg(3'd5, d); chk("R6 below half", d, stat(0, 1, 0, 0, 0));
      chk("R7 no offer below half", {31'd0, tx_valid}, 32'd0);
      push_word(32'h0000_0001);
      rd_reg(3'd5, d); chk("R6 at half", d, stat(0, 0, 0, 0, 1));
      drain(4);
      chk("R8 all pairs out", exp_q.size(), 0);
      rd_reg(3'd5, d); chk("R9 status after drain", d, stat(1, 1, 0, 1, 0));
      rd_reg(3'd6, d); chk("R10 ints after drain", d, 32'h7);
      wr_reg(3'd3, 32'd1);
      rd_reg(3'd5, d); chk("R11 underrun cleared", d, stat(1, 1, 0, 0, 0));

      // widths mixed per write, with interrupt mask
      wr_reg(3'd4, 32'd1);
      chk("R10 irq masked low", {31'd0, irq}, 32'd0);
      cur_req = "R2";
      set_ctrl(1, 1, 0, 2'd3, 0); push_word(32'hFFFF_FABC);
      set_ctrl(1, 1, 0, 2'd1, 0); push_word(32'hFFF2_3456);
      set_ctrl(1, 1, 0, 2'd2, 0); push_word(32'h1234_5678);
      set_ctrl(1, 1, 0, 2'd0, 0); push_word(32'h0000_BEEF);
      drain(4);
      chk("R2 widths drained", exp_q.size(), 0);
      chk("R10 irq on underrun", {31'd0, irq}, 32'd1);
      wr_reg(3'd4, 32'd2);
      wr_reg(3'd3, 32'd1);
      chk("R10 irq on half-empty", {31'd0, irq}, 32'd1);
      wr_reg(3'd4, 32'd1);
      chk("R11 irq after clear", {31'd0, irq}, 32'd0);

      // compact packing and forced non-compact
      cur_req = "R3";
      set_ctrl(1, 0, 1, 2'd0, 1); push_word(32'hBEEF_1234);
      set_ctrl(1, 0, 1, 2'd3, 1); push_word(32'h0ABC_0123);
      drain(4);
      chk("R3 compact drained", exp_q.size(), 0);
      cur_req = "R1";
      set_ctrl(1, 1, 0, 2'd1, 1); push_word(32'h0001_2345);
      set_ctrl(1, 1, 0, 2'd2, 1); push_word(32'hABCD_E012);
      rd_reg(3'd5, d); chk("R1 compact ignored at 18/20", d, stat(0, 1, 0, 0, 0));
      set_ctrl(1, 1, 0, 2'd0, 0); push_word(32'h11); push_word(32'h22);
      drain(4);
      chk("R1 mixed drained", exp_q.size(), 0);

      // gating
      cur_req = "R7";
      tx_ready = 1'b1;
      set_ctrl(0, 1, 1, 2'd0, 0);
      push_word(32'h1); push_word(32'h2); push_word(32'h3); push_word(32'h4);
      #1; chk("R7 disabled no offer", {31'd0, tx_valid}, 32'd0);
      set_ctrl(1, 0, 0, 2'd0, 0);
      #1; chk("R7 no slot no offer", {31'd0, tx_valid}, 32'd0);
      set_ctrl(1, 1, 0, 2'd0, 0);
      repeat (4) @(negedge clk);
      #1; chk("R7 gated drained", exp_q.size(), 0);

      // burst below half with write during pop
      cur_req = "R8";
      push_word(32'h5); push_word(32'h6);
      repeat (3) @(negedge clk);
      #1; chk("R7 two samples held", {31'd0, tx_valid}, 32'd0);
      push_word(32'h7); push_word(32'h8); push_word(32'h9);
      repeat (4) @(negedge clk);
      tx_ready = 1'b0;
      #1;
      chk("R8 odd leftover", exp_q.size(), 1);
      rd_reg(3'd5, d); chk("R9 leftover status", d, stat(0, 1, 0, 0, 0));

      // soft reset
      wr_reg(3'd4, 32'd3);
      soft_reset();
      #1;
      rd_reg(3'd5, d); chk("R12 soft reset status", d, stat(1, 1, 0, 0, 0));
      rd_reg(3'd0, d); chk("R12 soft reset ctrl", d, 32'd0);
      rd_reg(3'd4, d); chk("R12 soft reset mask", d, 32'd0);
      chk("R12 soft reset valid", {31'd0, tx_valid}, 32'd0);
      wr_reg(3'd1, 32'd1);

      // non-compact overrun
      cur_req = "R4";
      set_ctrl(0, 1, 0, 2'd2, 0);
      for (int i = 0; i < 9; i++) push_word(32'h1111 * (i + 1));
      rd_reg(3'd5, d); chk("R6 full flag", d, stat(0, 0, 1, 0, 0));
      set_ctrl(1, 1, 0, 2'd2, 0);
      rd_reg(3'd5, d); chk("R7 full offered", d, stat(0, 0, 1, 0, 1));
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
      #1;
      rd_reg(3'd5, d); chk("R9 full cleared", d, stat(0, 0, 0, 0, 1));
      chk("R8 offer held without ready", {31'd0, tx_valid}, 32'd1);
      drain(5);
      chk("R4 dropped word absent", exp_q.size(), 0);
      rd_reg(3'd5, d); chk("R9 empty after burst", d, stat(1, 1, 0, 1, 0));

      // compact overrun
      cur_req = "R5";
      set_ctrl(0, 1, 0, 2'd0, 1);
      for (int i = 0; i < 4; i++) push_word(32'h0101_0202 * (i + 1));
      rd_reg(3'd5, d); chk("R5 six stored, not full", d, stat(0, 0, 0, 0, 0));
      set_ctrl(1, 1, 0, 2'd0, 1);
      drain(5);
      chk("R5 fourth word absent", exp_q.size(), 0);
      rd_reg(3'd5, d); chk("R9 empty after compact", d, stat(1, 1, 0, 1, 0));

      report();
   end

endmodule